// File: doc/BRIEF.md
# Staged-Interrupt Watchdog Timer

This block is a watchdog timer for a slow timebase. A free-running counter, 16 bits wide by default, moves forward by one on each cycle where the low-speed tick enable is high. A programmable match register sets the counter value that counts as a timeout. Each time the counter reaches that value, the block raises a level interrupt. The counter keeps running after a match, so matches repeat once every full wrap of the counter.

Software keeps the system alive in one of three ways: it clears the interrupt, it kicks the watchdog, or it writes a new match value. Each of these empties the count of matches that no one has handled. The watchdog does not reset on the first missed match. It gives two warnings through the interrupt and asks for a system reset only on the third match in a row with no service. The reset request is a registered pulse that lasts one low-speed tick. The block clears its own state as it starts that pulse, then counts again from zero.

Top module: `wdog_staged`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) drives `irq` and `rst_req` low, zeroes the counter and the unhandled-match count, and loads the match register with all ones.
- R2: While enabled, the counter advances by one only on cycles with `tick_en` high. It wraps modulo 2^CNT_W and does not stop at a match, so consecutive matches come exactly 2^CNT_W ticks apart. The first tick after enabling sees a count of zero.
- R3: A match is a tick on which the counter equals the match register. At that tick's clock edge `irq` goes high (registered), and it stays high until a clear, a disable or a reset trip.
- R4: A pulse on `irq_clr` drops `irq` at the next edge and empties the unhandled-match count. A match on the same tick still sets `irq` and counts as one unhandled match.
- R5: A pulse on `kick` empties the unhandled-match count and leaves `irq` unchanged.
- R6: The third consecutive match without service raises `rst_req` at that tick's edge with `irq` low. `rst_req` falls at the edge of the next tick, so it is high for exactly one tick period.
- R7: The trip clears the counter, the unhandled-match count and `irq`. The counter holds at zero during the pulse, and the first tick after the pulse sees a count of zero.
- R8: With `wd_enable` low, the counter and the unhandled-match count stay at zero, and `irq` and `rst_req` are low from the next clock edge onwards. No match is detected.
- R9: A write (`match_we`) is compared from the next clock onwards and also empties the unhandled-match count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable from the low-speed timebase |
| wd_enable | input | 1 | Watchdog run enable |
| match_we | input | 1 | Write strobe for the match register |
| match_wdata | input | CNT_W (16) | New match value |
| irq_clr | input | 1 | Interrupt clear pulse (services the watchdog) |
| kick | input | 1 | Service pulse that leaves the interrupt alone |
| irq | output | 1 | Registered level interrupt on a match |
| rst_req | output | 1 | Registered reset request, one tick long |

## Verification
The bench shrinks the counter to 8 bits and feeds it one tick every four clocks. It then drives six patterns.

- **Reset default:** an enable right after reset, with no write, shows that the match value is all ones.
- **Disabled, then zero match:** a long stretch with the watchdog disabled, followed by an enable with a zero match value, checks both the absence of any event and the match at the very first tick.
- **No service:** a run with no service gives the exact tick of the trip and of the first match after it.
- **Regular clears:** clears after every interrupt must never trip, which tells a working service apart from one that is ignored.
- **Single kick:** one kick moves the trip a full period later, while `irq` stays high throughout.
- **Mid-run write:** a new match value written mid-run must move the next match at once and restart the count of misses. This gives a trip tick that differs from both the stale-value case and the no-clear case.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;

  // Width of the unhandled-match count: it holds 0 .. limit-1.
  function automatic int miss_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/wdog_match_reg.sv
module wdog_match_reg #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] MATCH_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] match_val
);

  logic [CNT_W-1:0] match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= MATCH_RST;
    end else if (we) begin
      match_q <= wdata;
    end
  end

  assign match_val = match_q;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] match_val,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  // A match is judged on the value the tick sees, before it advances.
  always_comb hit = adv && (cnt_q == match_val);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;   // wraps modulo 2^CNT_W
    end
  end

endmodule

// File: rtl/wdog_strike.sv
module wdog_strike #(
  parameter int MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  input  logic service,
  output logic trip
);

  localparam int MISS_W = wdog_pkg::miss_width(MISS_LIMIT);

  generate
    if (MISS_LIMIT < 2) begin : g_direct
      // Every match trips at once; no count is needed.
      logic unused_in;
      assign unused_in = clk | rst | clr | service;
      assign trip = hit;
    end else begin : g_count
      logic [MISS_W-1:0] miss_q;
      logic [MISS_W-1:0] base;

      // Service in the same cycle empties the count before this match is added.
      always_comb base = service ? '0 : miss_q;

      assign trip = hit && (base == MISS_W'(MISS_LIMIT - 1));

      always_ff @(posedge clk) begin
        if (rst || clr || trip) begin
          miss_q <= '0;
        end else if (hit) begin
          miss_q <= base + 1'b1;
        end else begin
          miss_q <= base;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick_en,
  input  logic hit,
  input  logic trip,
  input  logic irq_clr,
  output logic run,
  output logic irq,
  output logic rst_req
);

  import wdog_pkg::*;

  wd_state_e st_q, st_d;
  logic      irq_q, rst_req_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      WD_IDLE: if (en) st_d = trip ? WD_TRIP : WD_RUN;
      WD_RUN: begin
        if (!en)       st_d = WD_IDLE;
        else if (trip) st_d = WD_TRIP;
      end
      WD_TRIP: begin
        if (!en)          st_d = WD_IDLE;
        else if (tick_en) st_d = WD_RUN;
      end
      default: st_d = WD_IDLE;
    endcase
  end

  // The counter may advance whenever enabled, except while the reset pulse is out.
  assign run = en && (st_q != WD_TRIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= WD_IDLE;
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      rst_req_q <= (st_d == WD_TRIP);
      if (!en || trip) begin
        irq_q <= 1'b0;
      end else if (hit) begin
        irq_q <= 1'b1;
      end else if (irq_clr) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign irq     = irq_q;
  assign rst_req = rst_req_q;

endmodule

// File: rtl/wdog_staged.sv
module wdog_staged #(
  parameter int CNT_W      = 16,
  parameter int MISS_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wd_enable,
  input  logic             match_we,
  input  logic [CNT_W-1:0] match_wdata,
  input  logic             irq_clr,
  input  logic             kick,
  output logic             irq,
  output logic             rst_req
);

  logic [CNT_W-1:0] match_val;
  logic             run, adv, hit, trip, service, cnt_clr;

  assign adv     = run && tick_en;
  assign service = irq_clr || kick || match_we;
  assign cnt_clr = !run || trip;

  wdog_match_reg #(.CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .we        (match_we),
    .wdata     (match_wdata),
    .match_val (match_val)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clr),
    .adv       (adv),
    .match_val (match_val),
    .hit       (hit)
  );

  wdog_strike #(.MISS_LIMIT(MISS_LIMIT)) u_strike (
    .clk     (clk),
    .rst     (rst),
    .clr     (!run),
    .hit     (hit),
    .service (service),
    .trip    (trip)
  );

  wdog_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (wd_enable),
    .tick_en (tick_en),
    .hit     (hit),
    .trip    (trip),
    .irq_clr (irq_clr),
    .run     (run),
    .irq     (irq),
    .rst_req (rst_req)
  );

endmodule

// File: rtl/wdog_staged_chk.sv
module wdog_staged_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             wd_enable,
  input logic             match_we,
  input logic [CNT_W-1:0] match_wdata,
  input logic             irq_clr,
  input logic             kick,
  input logic             irq,
  input logic             rst_req
);

  logic unused_chk;
  assign unused_chk = match_we | kick | (|match_wdata);

  // R3: the interrupt only rises on an enabled tick
  p_irq_rise_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(tick_en) && $past(wd_enable)));

  // R4: the interrupt only falls on a clear, a disable or a trip
  p_irq_fall_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(irq_clr) || $past(!wd_enable) || $rose(rst_req)));

  // R6: the reset pulse starts on an enabled tick
  p_rst_entry_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> ($past(tick_en) && $past(wd_enable)));

  // R6: the reset pulse ends on a tick or on a disable
  p_rst_exit_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> ($past(tick_en) || $past(!wd_enable)));

  // R7: the interrupt is low while the reset pulse is out
  p_rst_irq_low_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !irq);

  // R8: disabling silences both outputs from the next edge
  p_disable_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !wd_enable |=> (!irq && !rst_req));

endmodule

bind wdog_staged wdog_staged_chk #(.CNT_W(CNT_W)) u_wdog_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_en     (tick_en),
  .wd_enable   (wd_enable),
  .match_we    (match_we),
  .match_wdata (match_wdata),
  .irq_clr     (irq_clr),
  .kick        (kick),
  .irq         (irq),
  .rst_req     (rst_req)
);

// File: tb/tb_wdog_staged.sv
`timescale 1ns/1ps
module tb_wdog_staged;

  localparam int CNT_W    = 8;
  localparam int TICK_DIV = 4;
  localparam int EV_IRQ   = 0;
  localparam int EV_RST   = 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_en = 1'b0;
  logic             wd_enable = 1'b0;
  logic             match_we = 1'b0;
  logic [CNT_W-1:0] match_wdata = '0;
  logic             irq_clr = 1'b0;
  logic             kick = 1'b0;
  logic             irq, rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  int tcount  = 0;
  int div     = 0;
  bit done    = 0;

  // Scoreboard of expected events: kind, tick count at which it is seen, requirement tag.
  int    exp_kind[$];
  int    exp_tick[$];
  string exp_tag[$];

  always #2 clk = ~clk;   // 250 MHz

  wdog_staged #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wd_enable(wd_enable),
    .match_we(match_we), .match_wdata(match_wdata), .irq_clr(irq_clr),
    .kick(kick), .irq(irq), .rst_req(rst_req)
  );

  // Low-speed timebase: one tick every TICK_DIV clocks.
  always @(negedge clk) begin
    div = (div + 1) % TICK_DIV;
    tick_en = (div == 0);
  end

  // Ticks consumed since the watchdog was enabled.
  always @(posedge clk) begin
    if (rst || !wd_enable) tcount <= 0;
    else if (tick_en)      tcount <= tcount + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int tk, input string tag);
    exp_kind.push_back(kind);
    exp_tick.push_back(tk);
    exp_tag.push_back(tag);
  endtask

  task automatic got_event(input int kind);
    if (exp_kind.size() == 0) begin
      chk(0, (kind == EV_IRQ) ? "R8 unexpected irq" : "R6 unexpected rst_req", tcount, -1);
    end else begin
      int    k  = exp_kind.pop_front();
      int    t  = exp_tick.pop_front();
      string tg = exp_tag.pop_front();
      chk(k == kind, {tg, " event kind"}, kind, k);
      chk(t == tcount, {tg, " event tick"}, tcount, t);
    end
  endtask

  // Monitor
  bit irq_q = 0, rr_q = 0;
  int rr_w = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (irq && !irq_q) got_event(EV_IRQ);
      if (rst_req && !rr_q) begin
        got_event(EV_RST);
        chk(irq == 1'b0, "R6 irq low at trip", int'(irq), 0);
      end
      if (rst_req) rr_w++;
      if (!rst_req && rr_q) begin
        chk(rr_w == TICK_DIV, "R6 pulse width in clocks", rr_w, TICK_DIV);
        rr_w = 0;
      end
    end
    irq_q = irq;
    rr_q  = rst_req;
  end

  task automatic wait_tc(input int n);
    while (tcount < n) @(negedge clk);
  endtask

  task automatic write_match(input int v);
    match_wdata = CNT_W'(v);
    match_we = 1'b1;
    @(negedge clk);
    match_we = 1'b0;
  endtask

  task automatic pulse_clr(input string tag);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq == 1'b0, {tag, " irq dropped by clear"}, int'(irq), 0);
  endtask

  task automatic pulse_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk(irq == 1'b1, "R5 kick leaves irq high", int'(irq), 1);
  endtask

  task automatic end_scn(input int stop, input string tag);
    wait_tc(stop);
    chk(exp_kind.size() == 0, {tag, " all expected events seen"}, exp_kind.size(), 0);
    exp_kind.delete(); exp_tick.delete(); exp_tag.delete();
    wd_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq low when disabled", int'(irq), 0);
    chk(rst_req == 1'b0, "R8 rst_req low when disabled", int'(rst_req), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq low after reset", int'(irq), 0);
    chk(rst_req == 1'b0, "R1 rst_req low after reset", int'(rst_req), 0);

    // Default match value (all ones), then a wrap period
    expect_ev(EV_IRQ, 256, "R1");
    expect_ev(EV_IRQ, 512, "R2");
    wd_enable = 1'b1;
    wait_tc(300);
    pulse_clr("R4");
    end_scn(520, "R2");

    // Disabled: nothing happens; then zero match on the first tick
    write_match(0);
    repeat (2400) @(negedge clk);
    chk(exp_kind.size() == 0 && irq == 1'b0, "R8 silent while disabled", int'(irq), 0);
    expect_ev(EV_IRQ, 1, "R2");
    wd_enable = 1'b1;
    end_scn(5, "R2");

    // No service: third match trips, counting restarts
    write_match(5);
    expect_ev(EV_IRQ, 6, "R3");
    expect_ev(EV_RST, 518, "R6");
    expect_ev(EV_IRQ, 525, "R7");
    wd_enable = 1'b1;
    end_scn(530, "R6");

    // Regular clears never trip
    write_match(10);
    expect_ev(EV_IRQ, 11, "R3");
    expect_ev(EV_IRQ, 267, "R4");
    expect_ev(EV_IRQ, 523, "R4");
    expect_ev(EV_IRQ, 779, "R2");
    wd_enable = 1'b1;
    wait_tc(20);  pulse_clr("R4");
    wait_tc(280); pulse_clr("R4");
    wait_tc(540); pulse_clr("R4");
    end_scn(790, "R4");

    // Kick postpones the trip by one period
    write_match(3);
    expect_ev(EV_IRQ, 4, "R3");
    expect_ev(EV_RST, 772, "R5");
    expect_ev(EV_IRQ, 777, "R7");
    wd_enable = 1'b1;
    wait_tc(10); pulse_kick();
    end_scn(790, "R5");

    // Mid-run write: new value at once, misses restart
    write_match(200);
    expect_ev(EV_IRQ, 201, "R3");
    expect_ev(EV_RST, 999, "R9");
    expect_ev(EV_IRQ, 1231, "R9");
    wd_enable = 1'b1;
    wait_tc(470); write_match(230);
    end_scn(1240, "R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule